// File: doc/BRIEF.md
# Event-Flag UART with Word Register Interface

The block is a serial port with a small register file of 32-bit words. Software sends a byte by writing the data word; the block shifts it out as an 8N1 frame, least significant bit first. Each bit lasts a number of clock cycles set by the divisor word. The receiver watches the input line for a falling edge and samples each bit at its middle. It keeps one finished byte in a holding register, which software reads back through the same data word.

Two sticky event flags live in the status word, one for each direction. A hardware event sets a flag, and software clears it by writing a one to that bit. Software enables each flag towards the single level interrupt output with its own bit in the control word. While the receive event is still set, the holding register refuses new bytes. The transmit-ready bit of the status word always reads as one. The pass-through bit of the control word and the break bit of the debug word are stored only and have no effect.

The transmitter runs a four-state machine. IDLE goes to START when the data word is written. START goes to DATA after one bit time. DATA stays for eight bit times and then goes to STOP. STOP goes back to IDLE after one bit time.

The receiver runs its own four-state machine. IDLE goes to START when the line is seen low. START goes to DATA if the line is still low at mid-bit, and back to IDLE if it is high. DATA takes eight samples and then goes to STOP. STOP goes to IDLE at mid-stop, where it hands over the byte only if the line is high.

Top module: `evt_uart`

## Requirements
- R1: After reset, every word reads 0 except status, which reads 1. The interrupt is low and the transmit line is high.
- R2: The word map uses byte addresses. Data is at 0x00, divisor at 0x04, status at 0x08, control at 0x0C and debug at 0x10. Divisor, control and debug store and return all 32 bits as written.
- R3: A write takes effect only when all four byte enables are 1. A write with any byte enable at 0 changes no word, no flag and no line.
- R4: An address at 0x14 or above, or one whose two low bits are not zero, reads as 0, and writes to it change nothing.
- R5: Status bit 0 always reads 1 and no write changes it. Bit 1 is the receive event and bit 2 is the transmit event. Bits 31 to 3 read 0.
- R6: A write to the data word sends bits 7 to 0 as a frame: a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts the divisor's value in clock cycles. The write sets the transmit event and does not change what the data word reads.
- R7: A data write that arrives while a frame is on the line is not sent and does not change that frame. It still sets the transmit event.
- R8: A status write clears bit 1 and bit 2 wherever the written value has a 1 in that position. A 0 leaves the bit as it was.
- R9: The interrupt is high exactly when (control bit 0 and the receive event) or (control bit 1 and the transmit event). Control bit 2 is stored only.
- R10: A received byte, sampled at mid-bit, is loaded into the data word (read zero-extended) and sets the receive event.
- R11: A byte that finishes while the receive event is set is dropped, and the held byte stays unchanged.
- R12: A frame whose stop bit is sampled low is dropped and does not set the receive event.
- R13: Only the low 16 bits of the divisor set the bit time. Values 0 and 1 give a bit time of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 5 | Byte address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte enables; a write needs all four set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The properties assume that a write lasts exactly one cycle. They also assume the serial input is idle high and changes no faster than the bit time, so a frame that arrives is seen in full. The bench keeps to this. It drives every bus signal and rxd only at falling clock edges, and it builds each incoming frame from whole bit times at the divisor in force. It waits for each outgoing frame to leave the line before it writes the next byte, except in the one step that deliberately writes while a frame is being sent.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_DIV  = 3'd1,
        OFS_STAT = 3'd2,
        OFS_CTRL = 3'd3,
        OFS_DBG  = 3'd4
    } reg_ofs_e;

    localparam int ST_RDY  = 0;
    localparam int ST_RXEV = 1;
    localparam int ST_TXEV = 2;
    localparam int CT_RXIE = 0;
    localparam int CT_TXIE = 1;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/evt_uart_regs.sv
module evt_uart_regs
    import evt_uart_pkg::*;
#(
    parameter int WORD_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aligned,
    input  logic [WORD_W-1:0]  word,
    input  logic               bus_wr,
    input  logic [3:0]         bus_be,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               tx_start,
    output logic [BYTE_W-1:0]  tx_byte,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic [CNT_W-1:0]   div_lo,
    output logic               irq
);
    logic [REG_W-1:0]  div_q, ctrl_q, dbg_q;
    logic [BYTE_W-1:0] rx_hold_q;
    logic              rx_evt_q, tx_evt_q;
    logic              wr_ok;
    logic              hit_data, hit_div, hit_stat, hit_ctrl, hit_dbg;

    assign wr_ok    = bus_wr && (&bus_be);
    assign hit_data = aligned && (int'(word) == int'(OFS_DATA));
    assign hit_div  = aligned && (int'(word) == int'(OFS_DIV));
    assign hit_stat = aligned && (int'(word) == int'(OFS_STAT));
    assign hit_ctrl = aligned && (int'(word) == int'(OFS_CTRL));
    assign hit_dbg  = aligned && (int'(word) == int'(OFS_DBG));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            ctrl_q    <= '0;
            dbg_q     <= '0;
            rx_hold_q <= '0;
            rx_evt_q  <= 1'b0;
            tx_evt_q  <= 1'b0;
        end else begin
            if (wr_ok && hit_div)  div_q  <= bus_wdata;
            if (wr_ok && hit_ctrl) ctrl_q <= bus_wdata;
            if (wr_ok && hit_dbg)  dbg_q  <= bus_wdata;
            if (wr_ok && hit_data)
                tx_evt_q <= 1'b1;
            else if (wr_ok && hit_stat && bus_wdata[ST_TXEV])
                tx_evt_q <= 1'b0;
            if (rx_valid && !rx_evt_q) begin
                rx_hold_q <= rx_byte;
                rx_evt_q  <= 1'b1;
            end else if (wr_ok && hit_stat && bus_wdata[ST_RXEV]) begin
                rx_evt_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (int'(word))
                int'(OFS_DATA): bus_rdata[BYTE_W-1:0] = rx_hold_q;
                int'(OFS_DIV):  bus_rdata = div_q;
                int'(OFS_STAT): begin
                    bus_rdata[ST_RDY]  = 1'b1;
                    bus_rdata[ST_RXEV] = rx_evt_q;
                    bus_rdata[ST_TXEV] = tx_evt_q;
                end
                int'(OFS_CTRL): bus_rdata = ctrl_q;
                int'(OFS_DBG):  bus_rdata = dbg_q;
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign tx_start = wr_ok && hit_data;
    assign tx_byte  = bus_wdata[BYTE_W-1:0];
    assign div_lo   = div_q[CNT_W-1:0];
    assign irq      = (ctrl_q[CT_RXIE] && rx_evt_q) || (ctrl_q[CT_TXIE] && tx_evt_q);
endmodule

// File: rtl/evt_uart_tx.sv
module evt_uart_tx
    import evt_uart_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_per,
    input  logic              start,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              txd
);
    localparam int IDX_W = $clog2(BYTE_W);

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shift;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shift <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (start) begin
                    shift <= byte_in;
                    cnt   <= bit_per - CNT_W'(1);
                    state <= TX_START;
                end
                TX_START: if (cnt == '0) begin
                    cnt   <= bit_per - CNT_W'(1);
                    idx   <= '0;
                    state <= TX_DATA;
                end else cnt <= cnt - CNT_W'(1);
                TX_DATA: if (cnt == '0) begin
                    cnt   <= bit_per - CNT_W'(1);
                    shift <= shift >> 1;
                    if (idx == IDX_W'(BYTE_W - 1)) state <= TX_STOP;
                    else idx <= idx + IDX_W'(1);
                end else cnt <= cnt - CNT_W'(1);
                TX_STOP: if (cnt == '0) state <= TX_IDLE;
                         else cnt <= cnt - CNT_W'(1);
            endcase
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift[0];
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx
    import evt_uart_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_per,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int IDX_W = $clog2(BYTE_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shift;
    logic [1:0]        sync;
    logic              rx_s;
    logic [CNT_W-1:0]  half;

    assign rx_s = sync[1];
    assign half = bit_per >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync  <= 2'b11;
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shift <= '0;
        end else begin
            sync <= {sync[0], rxd};
            unique case (state)
                RX_IDLE: if (!rx_s) begin
                    cnt   <= half - CNT_W'(1);
                    state <= RX_START;
                end
                RX_START: if (cnt == '0) begin
                    if (!rx_s) begin
                        cnt   <= bit_per - CNT_W'(1);
                        idx   <= '0;
                        state <= RX_DATA;
                    end else state <= RX_IDLE;
                end else cnt <= cnt - CNT_W'(1);
                RX_DATA: if (cnt == '0) begin
                    shift <= {rx_s, shift[BYTE_W-1:1]};
                    cnt   <= bit_per - CNT_W'(1);
                    if (idx == IDX_W'(BYTE_W - 1)) state <= RX_STOP;
                    else idx <= idx + IDX_W'(1);
                end else cnt <= cnt - CNT_W'(1);
                RX_STOP: if (cnt == '0) state <= RX_IDLE;
                         else cnt <= cnt - CNT_W'(1);
            endcase
        end
    end

    always_comb begin
        rx_valid = (state == RX_STOP) && (cnt == '0) && rx_s;
        rx_byte  = shift;
    end
endmodule

// File: rtl/evt_uart.sv
module evt_uart
    import evt_uart_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              txd,
    input  logic              rxd
);
    localparam int WORD_W = ADDR_W - 2;

    logic              tx_start, rx_valid, aligned;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    logic [CNT_W-1:0]  div_lo, bit_per;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign bit_per = (div_lo < CNT_W'(2)) ? CNT_W'(2) : div_lo;

    evt_uart_regs #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .aligned(aligned),
        .word(bus_addr[ADDR_W-1:2]), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_start(tx_start), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .div_lo(div_lo), .irq(irq)
    );

    evt_uart_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_per(bit_per),
        .start(tx_start), .byte_in(tx_byte), .txd(txd)
    );

    evt_uart_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_per(bit_per),
        .rxd(rxd), .rx_valid(rx_valid), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/evt_uart_chk.sv
module evt_uart_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              rx_evt,
    input logic              tx_evt,
    input logic [7:0]        rx_hold
);
    logic       al;
    logic       full_wr;
    logic [31:0] w;
    assign al      = (bus_addr[1:0] == 2'b00);
    assign w       = 32'(bus_addr[ADDR_W-1:2]);
    assign full_wr = bus_wr && (&bus_be) && al;

    p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!al || w > 32'd4) |-> (bus_rdata == 32'd0));

    p_status_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (al && w == 32'd2) |-> (bus_rdata[0] && bus_rdata[31:3] == 29'd0));

    p_tx_event_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && w == 32'd0) |=> tx_evt);

    p_partial_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(&bus_be) && !tx_evt) |=> !tx_evt);

    p_w1c_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && w == 32'd2 && bus_wdata[2]) |=> !tx_evt);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_evt || tx_evt));

    p_hold_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !(full_wr && w == 32'd2 && bus_wdata[1]))
        |=> (rx_evt && $stable(rx_hold)));
endmodule

bind evt_uart evt_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_evt(u_regs.rx_evt_q), .tx_evt(u_regs.tx_evt_q),
    .rx_hold(u_regs.rx_hold_q)
);

// File: tb/evt_uart_test.sv
module evt_uart_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, txd;
    logic        rxd = 1'b1;

    int checks = 0;
    int errors = 0;
    int mon_per = 8;
    int frames_seen = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    evt_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .txd(txd), .rxd(rxd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        wr(5'h00, {24'hABCDEF, b});
    endtask

    task automatic wait_tx;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * mon_per) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (8) @(negedge clk);
        end
        rxd = stop_ok;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes frames on txd and compares with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                logic [7:0] got;
                repeat (mon_per / 2) @(negedge clk);
                check("R6 start bit", {31'd0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (mon_per) @(negedge clk);
                    got[i] = txd;
                end
                repeat (mon_per) @(negedge clk);
                check("R6 stop bit", {31'd0, txd}, 32'd1);
                frames_seen++;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected frame actual %h expected none", got);
                end else begin
                    check("R6 frame byte", {24'd0, got}, {24'd0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 data", 5'h00, 32'd0);
        rd_chk("R1 divisor", 5'h04, 32'd0);
        rd_chk("R1 status", 5'h08, 32'd1);
        rd_chk("R1 control", 5'h0C, 32'd0);
        rd_chk("R1 debug", 5'h10, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 txd", {31'd0, txd}, 32'd1);
        // R2 plain storage
        wr(5'h04, 32'd8);
        wr(5'h0C, 32'hFFFF_FFF8);
        wr(5'h10, 32'hA5A5_0001);
        rd_chk("R2 divisor", 5'h04, 32'd8);
        rd_chk("R2 control", 5'h0C, 32'hFFFF_FFF8);
        rd_chk("R2 debug", 5'h10, 32'hA5A5_0001);
        // R4 unmapped and unaligned
        rd_chk("R4 read 0x14", 5'h14, 32'd0);
        rd_chk("R4 read 0x1C", 5'h1C, 32'd0);
        rd_chk("R4 unaligned read", 5'h05, 32'd0);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h06, 32'h0000_0055);
        rd_chk("R4 divisor kept", 5'h04, 32'd8);
        rd_chk("R4 debug kept", 5'h10, 32'hA5A5_0001);
        rd_chk("R4 status kept", 5'h08, 32'd1);
        // R3 partial writes
        wr(5'h04, 32'h0000_0033, 4'b0011);
        rd_chk("R3 divisor unchanged", 5'h04, 32'd8);
        wr(5'h00, 32'h0000_0042, 4'b0111);
        repeat (20) @(negedge clk);
        rd_chk("R3 no tx event", 5'h08, 32'd1);
        // R5 ready bit not writable
        wr(5'h08, 32'hFFFF_FFFF);
        rd_chk("R5 status after ones", 5'h08, 32'd1);
        // R6 transmit
        send_tx(8'hA5);
        rd_chk("R6 data readback unchanged", 5'h00, 32'd0);
        wait_tx();
        rd_chk("R6 tx event set", 5'h08, 32'd5);
        check("R9 irq masked", {31'd0, irq}, 32'd0);
        wr(5'h0C, 32'd2);
        check("R9 irq tx enabled", {31'd0, irq}, 32'd1);
        wr(5'h08, 32'd2);
        rd_chk("R8 zero bit keeps tx event", 5'h08, 32'd5);
        wr(5'h08, 32'd4);
        rd_chk("R8 tx event cleared", 5'h08, 32'd1);
        check("R9 irq dropped", {31'd0, irq}, 32'd0);
        // R6 patterns
        send_tx(8'h00); wait_tx();
        send_tx(8'hFF); wait_tx();
        send_tx(8'h81); wait_tx();
        // R7 write while busy
        wr(5'h08, 32'd4);
        send_tx(8'h5A);
        repeat (20) @(negedge clk);
        wr(5'h00, 32'h0000_00C3);
        wait_tx();
        repeat (100) @(negedge clk);
        rd_chk("R7 tx event still set", 5'h08, 32'd5);
        check("R7 frame count", frames_seen, 32'd5);
        // R10 receive
        wr(5'h08, 32'd6);
        wr(5'h0C, 32'd1);
        send_rx(8'h3C, 1'b1);
        rd_chk("R10 rx event", 5'h08, 32'd3);
        rd_chk("R10 data", 5'h00, 32'h3C);
        check("R9 irq rx", {31'd0, irq}, 32'd1);
        // R11 refused while pending
        send_rx(8'hC7, 1'b1);
        rd_chk("R11 data held", 5'h00, 32'h3C);
        wr(5'h08, 32'd2);
        rd_chk("R8 rx event cleared", 5'h08, 32'd1);
        check("R9 irq rx cleared", {31'd0, irq}, 32'd0);
        send_rx(8'hC7, 1'b1);
        rd_chk("R10 second byte", 5'h00, 32'hC7);
        wr(5'h08, 32'd2);
        // R12 bad stop bit
        send_rx(8'h5E, 1'b0);
        rd_chk("R12 no rx event", 5'h08, 32'd1);
        rd_chk("R12 data kept", 5'h00, 32'hC7);
        // R13 small divisor
        wr(5'h04, 32'd1);
        mon_per = 2;
        send_tx(8'h96);
        wait_tx();
        wr(5'h04, 32'h0001_0000);
        send_tx(8'h69);
        wait_tx();
        check("R13 frame count", frames_seen, 32'd7);
        check("R6 queue drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule